// File: doc/BRIEF.md
# UART with Automatic Flow Control

This block is a small serial port: a transmitter and a receiver, each with an eight-entry byte queue, behind a plain synchronous register port. Software sets a 16-bit baud divider and picks 7- or 8-bit characters. Each character has one start bit, the data bits sent least significant bit first, and one stop bit. There is no parity. Software can also hold the output line low to send a break.

Flow control can run without software. With automatic request-to-send enabled, the block drops `rts_out` when the receive queue nears full. A two-bit field sets how many free slots count as near full. With automatic clear-to-send enabled, a deasserted `cts_in` stops the transmitter from starting a new character. Either line can have its active level inverted. The port also provides an interrupt output, an interrupt identification code, and a status word that reports queue fill levels, idle and done conditions, and a sticky receive overflow flag.

Register map (3-bit address): 0 DATA (a write queues a byte for transmission; a read returns and removes the oldest received byte, or 0 if none). 1 INTEN (bit0 receive interrupt enable, bit1 transmit interrupt enable). 2 IID/FLUSH (read: identification code; write: bit0 flushes the receive queue, bit1 flushes the transmit queue). 3 LINE (bits[1:0] character size, bit2 break; reset value 0x3). 4 CTRL (bit0 receiver enable, bit1 transmitter enable, bit2 auto-RTS, bit3 auto-CTS, bits[5:4] threshold select, bit6 RTS invert, bit7 CTS invert; reset value 0x03). 5 STATUS (read only). 6 BAUD (bits[15:0]; reset value 0).

Top module: `uart_flowctl`

## Requirements
- R1: Each bit on `txd` lasts exactly 8*(BAUD+1) clock cycles.
- R2: In 8-bit mode (LINE[1:0]=11) a frame is one low start bit, then 8 data bits least significant bit first, then one high stop bit. In 7-bit mode (LINE[1:0]=10) the frame carries only the low 7 data bits.
- R3: While LINE bit2 is 1, `txd` is held at 0. When the bit is cleared, the line returns high.
- R4: A frame received on `rxd` is placed in the receive queue and returned by a DATA read. In 7-bit mode the returned bit7 is 0. The start bit is sampled again at its middle, and a start bit that is no longer low at that point is rejected.
- R5: A byte that arrives while the receive queue holds 8 entries is discarded, and STATUS bit4 is set. The bit stays set until STATUS is read, and that read clears it.
- R6: With CTRL bit2 set, `rts_out` is 0 (CTRL bit6 = 0) while the receive queue has at most N free entries, and 1 otherwise. N is chosen by CTRL[5:4]: 00 gives 3, 01 gives 2, 10 gives 1, 11 gives 4. CTRL bit6 inverts the output. With CTRL bit2 clear, `rts_out` is 1 (0 if inverted). STATUS bit6 mirrors `rts_out`.
- R7: With CTRL bit3 set, no new character starts while `cts_in` XOR CTRL bit7 is 0. Transmission resumes when that value becomes 1. With CTRL bit3 clear, `cts_in` has no effect.
- R8: IID reads 0x4 when the receive interrupt is enabled and the receive queue is not empty. Otherwise it reads 0x2 when the transmit interrupt is enabled and the transmit queue is empty. Otherwise it reads 0x1. `irq` is 1 exactly when IID bit0 is 0.
- R9: Writing IID/FLUSH with bit0 empties the receive queue, and writing it with bit1 empties the transmit queue.
- R10: With CTRL bit1 clear, queued bytes are held and are sent once the bit is set. With CTRL bit0 clear, frames on `rxd` are ignored.
- R11: STATUS bits: 0 receive data present, 1 transmit space, 2 receiver idle, 3 transmitter idle, 4 overflow, 5 transmit full, 6 RTS level, 7 synchronized `cts_in`, 8 transmit queue empty, 9 transmit done (queue empty and transmitter idle). Bits [23:16] hold the receive fill level and bits [31:24] the transmit fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on DATA, clears overflow on STATUS) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_in | input | 1 | Clear-to-send input |
| rts_out | output | 1 | Request-to-send output |
| irq | output | 1 | Interrupt request |

## Verification
A receiver that samples at the wrong phase, or that counts the wrong number of bits, changes the bytes read back from DATA on the first frame it handles. A transmitter bit counter that is off by one shows up within one frame as a shifted byte or a missing stop bit at `txd`. An error in the receive fill count or in the threshold decode moves the `rts_out` transition to a different byte count, and the bench checks `rts_out` after every received byte for every threshold setting. A lost or stuck overflow flag shows up on the first STATUS read after the ninth byte, or on the read that follows it.

// File: rtl/uart_fc_pkg.sv
// Shared types and constants for the flow-controlled UART.
// Assumes a 3-bit register address space.
package uart_fc_pkg;

    localparam logic [2:0] A_DATA   = 3'd0;
    localparam logic [2:0] A_INTEN  = 3'd1;
    localparam logic [2:0] A_IIDFL  = 3'd2;
    localparam logic [2:0] A_LINE   = 3'd3;
    localparam logic [2:0] A_CTRL   = 3'd4;
    localparam logic [2:0] A_STATUS = 3'd5;
    localparam logic [2:0] A_BAUD   = 3'd6;

    // Oversampling ticks per bit, minus one
    localparam logic [2:0] PH_LAST = 3'd7;
    // Tick index where the start bit is confirmed
    localparam logic [2:0] PH_MID  = 3'd3;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_START,
        SER_DATA,
        SER_STOP
    } ser_state_t;

    // Free-entry margin at which RTS drops, selected by a 2-bit field
    function automatic logic [2:0] rts_margin(input logic [1:0] sel);
        case (sel)
            2'b00:   rts_margin = 3'd3;
            2'b01:   rts_margin = 3'd2;
            2'b10:   rts_margin = 3'd1;
            default: rts_margin = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/uart_fc_fifo.sv
// Synchronous byte queue with clear, full/empty flags and fill count.
// Assumes DEPTH is a power of two. Pushes when full and pops when
// empty are dropped; clear wins over push and pop.
module uart_fc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     push,
    input  logic [W-1:0]             din,
    input  logic                     pop,
    output logic [W-1:0]             dout,
    output logic                     full,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rd_ptr];
    assign count   = cnt;

    // Store incoming byte at the write pointer
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Advance pointers and fill count
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/uart_fc_baud.sv
// Oversampling tick generator: one pulse every (div+1) clocks.
// Eight ticks make one bit period.
module uart_fc_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count up to the divider, pulse and restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick);

endmodule

// File: rtl/uart_fc_tx.sv
// Serial transmitter: start bit, 7 or 8 data bits LSB first, one stop
// bit, each bit eight ticks long. A character starts only on a tick,
// when enabled, when the queue has data and when may_start is high.
// The output flop is forced low while brk is set.
module uart_fc_tx
    import uart_fc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en,
    input  logic         brk,
    input  logic         eight,
    input  logic         may_start,
    input  logic         q_empty,
    input  logic [W-1:0] q_data,
    output logic         pop,
    output logic         txd,
    output logic         idle
);
    ser_state_t   st;
    logic [2:0]   ph;
    logic [2:0]   bidx;
    logic [W-1:0] sh;
    logic         ser;
    logic         txd_q;
    logic [2:0]   last_bit;

    assign last_bit = eight ? 3'd7 : 3'd6;
    assign pop      = (st == SER_IDLE) && tick && en && !q_empty && may_start;
    assign idle     = (st == SER_IDLE);
    assign txd      = txd_q;

    // Line level implied by the current state
    always_comb begin
        case (st)
            SER_START: ser = 1'b0;
            SER_DATA:  ser = sh[0];
            default:   ser = 1'b1;
        endcase
    end

    // Frame sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= SER_IDLE;
            ph   <= '0;
            bidx <= '0;
            sh   <= '0;
        end else begin
            case (st)
                SER_IDLE: begin
                    if (pop) begin
                        st <= SER_START;
                        sh <= q_data;
                        ph <= '0;
                    end
                end
                SER_START: begin
                    if (tick) begin
                        if (ph == PH_LAST) begin
                            st   <= SER_DATA;
                            ph   <= '0;
                            bidx <= '0;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
                SER_DATA: begin
                    if (tick) begin
                        if (ph == PH_LAST) begin
                            ph <= '0;
                            sh <= sh >> 1;
                            if (bidx == last_bit) st <= SER_STOP;
                            else                  bidx <= bidx + 1'b1;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (ph == PH_LAST) begin
                            st <= SER_IDLE;
                            ph <= '0;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Registered line output with break override
    always_ff @(posedge clk) begin
        if (!rst_n) txd_q <= 1'b1;
        else        txd_q <= brk ? 1'b0 : ser;
    end

    p_break_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !txd_q);

    p_cts_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SER_START && $past(st) == SER_IDLE) |-> $past(may_start));

endmodule

// File: rtl/uart_fc_rx.sv
// Serial receiver on a synchronized input. The start edge is seen on
// a tick and confirmed four ticks later (mid-bit); each data bit and
// the stop bit are sampled eight ticks apart. No framing check.
// Dropping en returns the receiver to idle at once.
module uart_fc_rx
    import uart_fc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en,
    input  logic         eight,
    input  logic         rxs,
    output logic         push,
    output logic [W-1:0] data,
    output logic         idle
);
    ser_state_t   st;
    logic [2:0]   ph;
    logic [2:0]   bidx;
    logic [W-1:0] buf_q;
    logic [2:0]   last_bit;

    assign last_bit = eight ? 3'd7 : 3'd6;
    assign push     = en && (st == SER_STOP) && tick && (ph == PH_LAST);
    assign data     = buf_q;
    assign idle     = (st == SER_IDLE);

    // Start detection, mid-bit sampling and frame completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= SER_IDLE;
            ph    <= '0;
            bidx  <= '0;
            buf_q <= '0;
        end else if (!en) begin
            st <= SER_IDLE;
            ph <= '0;
        end else begin
            case (st)
                SER_IDLE: begin
                    if (tick && !rxs) begin
                        st    <= SER_START;
                        ph    <= '0;
                        buf_q <= '0;
                    end
                end
                SER_START: begin
                    if (tick) begin
                        if (ph == PH_MID) begin
                            ph   <= '0;
                            bidx <= '0;
                            st   <= rxs ? SER_IDLE : SER_DATA;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
                SER_DATA: begin
                    if (tick) begin
                        if (ph == PH_LAST) begin
                            ph          <= '0;
                            buf_q[bidx] <= rxs;
                            if (bidx == last_bit) st <= SER_STOP;
                            else                  bidx <= bidx + 1'b1;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (ph == PH_LAST) begin
                            st <= SER_IDLE;
                            ph <= '0;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    p_seven_bit_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !eight && $past(!eight)) |-> !buf_q[W-1]);

endmodule

// File: rtl/uart_flowctl.sv
// Flow-controlled UART top: register port, synchronizers, queues,
// RTS/CTS logic, interrupt identification and status word.
// Reads are combinational in the strobe cycle; a DATA read pops the
// receive queue and a STATUS read clears the overflow flag.
module uart_flowctl
    import uart_fc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DIV_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        rxd,
    output logic        txd,
    input  logic        cts_in,
    output logic        rts_out,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH) + 1;

    // Control state
    logic [1:0]       inten;
    logic [1:0]       line_sz;
    logic             brk;
    logic             rx_en, tx_en, auto_rts, auto_cts, rts_inv, cts_inv;
    logic [1:0]       thr_sel;
    logic [DIV_W-1:0] baud;
    logic             ovf;
    logic             rts_q;
    logic             rx_m, rx_s, cts_m, cts_s;

    logic             tick;
    logic             tx_pop, tx_idle, rx_push, rx_idle;
    logic [7:0]       tx_dout, rx_dout, rx_byte;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0]    tx_cnt, rx_cnt, rx_free;
    logic             wr_data, rd_data, rd_stat, wr_flush;
    logic             may_start, rts_act;
    logic             rx_pend, tx_pend;
    logic [2:0]       iid;
    logic [31:0]      status;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign wr_data  = reg_wr && (reg_addr == A_DATA);
    assign rd_data  = reg_rd && (reg_addr == A_DATA);
    assign rd_stat  = reg_rd && (reg_addr == A_STATUS);
    assign wr_flush = reg_wr && (reg_addr == A_IIDFL);

    // Two-flop synchronizers for the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_m <= 1'b1; rx_s <= 1'b1;
            cts_m <= 1'b1; cts_s <= 1'b1;
        end else begin
            rx_m <= rxd;    rx_s <= rx_m;
            cts_m <= cts_in; cts_s <= cts_m;
        end
    end

    // Register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inten    <= 2'b00;
            line_sz  <= 2'b11;
            brk      <= 1'b0;
            rx_en    <= 1'b1;
            tx_en    <= 1'b1;
            auto_rts <= 1'b0;
            auto_cts <= 1'b0;
            thr_sel  <= 2'b00;
            rts_inv  <= 1'b0;
            cts_inv  <= 1'b0;
            baud     <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_INTEN: inten <= reg_wdata[1:0];
                A_LINE: begin
                    line_sz <= reg_wdata[1:0];
                    brk     <= reg_wdata[2];
                end
                A_CTRL: begin
                    rx_en    <= reg_wdata[0];
                    tx_en    <= reg_wdata[1];
                    auto_rts <= reg_wdata[2];
                    auto_cts <= reg_wdata[3];
                    thr_sel  <= reg_wdata[5:4];
                    rts_inv  <= reg_wdata[6];
                    cts_inv  <= reg_wdata[7];
                end
                A_BAUD: baud <= reg_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    // Sticky overflow: set on a dropped byte, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovf <= 1'b0;
        else if (rx_push && rx_full) ovf <= 1'b1;
        else if (rd_stat)            ovf <= 1'b0;
    end

    // RTS from receive free space, with polarity select
    assign rx_free = CW'(DEPTH) - rx_cnt;
    assign rts_act = !auto_rts || (rx_free > CW'(rts_margin(thr_sel)));
    always_ff @(posedge clk) begin
        if (!rst_n) rts_q <= 1'b1;
        else        rts_q <= rts_act ^ rts_inv;
    end
    assign rts_out = rts_q;

    assign may_start = !auto_cts || (cts_s ^ cts_inv);

    uart_fc_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(baud), .tick(tick)
    );

    uart_fc_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(wr_flush && reg_wdata[1]),
        .push(wr_data), .din(reg_wdata[7:0]), .pop(tx_pop),
        .dout(tx_dout), .full(tx_full), .empty(tx_empty), .count(tx_cnt)
    );

    uart_fc_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(wr_flush && reg_wdata[0]),
        .push(rx_push), .din(rx_byte), .pop(rd_data),
        .dout(rx_dout), .full(rx_full), .empty(rx_empty), .count(rx_cnt)
    );

    uart_fc_tx #(.W(8)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(tx_en), .brk(brk),
        .eight(line_sz[0]), .may_start(may_start), .q_empty(tx_empty),
        .q_data(tx_dout), .pop(tx_pop), .txd(txd), .idle(tx_idle)
    );

    uart_fc_rx #(.W(8)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(rx_en),
        .eight(line_sz[0]), .rxs(rx_s), .push(rx_push), .data(rx_byte),
        .idle(rx_idle)
    );

    // Interrupt identification, receive before transmit
    assign rx_pend = inten[0] && !rx_empty;
    assign tx_pend = inten[1] && tx_empty;
    always_comb begin
        if (rx_pend)      iid = 3'b100;
        else if (tx_pend) iid = 3'b010;
        else              iid = 3'b001;
    end
    assign irq = !iid[0];

    // Status word assembly
    always_comb begin
        status        = '0;
        status[0]     = !rx_empty;
        status[1]     = !tx_full;
        status[2]     = rx_idle;
        status[3]     = tx_idle;
        status[4]     = ovf;
        status[5]     = tx_full;
        status[6]     = rts_q;
        status[7]     = cts_s;
        status[8]     = tx_empty;
        status[9]     = tx_empty && tx_idle;
        status[23:16] = 8'(rx_cnt);
        status[31:24] = 8'(tx_cnt);
    end

    // Read multiplexer
    always_comb begin
        case (reg_addr)
            A_DATA:   reg_rdata = rx_empty ? 32'd0 : {24'd0, rx_dout};
            A_INTEN:  reg_rdata = {30'd0, inten};
            A_IIDFL:  reg_rdata = {29'd0, iid};
            A_LINE:   reg_rdata = {29'd0, brk, line_sz};
            A_CTRL:   reg_rdata = {24'd0, cts_inv, rts_inv, thr_sel,
                                   auto_cts, auto_rts, tx_en, rx_en};
            A_STATUS: reg_rdata = status;
            A_BAUD:   reg_rdata = 32'(baud);
            default:  reg_rdata = 32'd0;
        endcase
    end

    p_ovf_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(rx_full));

    p_rts_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(auto_rts && !rts_inv && rx_empty) |-> rts_out);

endmodule

// File: tb/uart_flowctl_test.sv
`timescale 1ns/1ps
module uart_flowctl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rxd = 1'b1;
    logic        txd;
    logic        cts_in = 1'b1;
    logic        rts_out;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    int per = 8;
    bit done = 0;

    always #10 clk = ~clk;

    uart_flowctl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rxd(rxd), .txd(txd), .cts_in(cts_in), .rts_out(rts_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_baud(input int d);
        wr(3'd6, d);
        per = 8 * (d + 1);
    endtask

    // Expected RTS level after k bytes with the given threshold select
    function automatic logic exp_rts(input int k, input int sel, input bit inv);
        int m;
        m = (sel == 0) ? 3 : (sel == 1) ? 2 : (sel == 2) ? 1 : 4;
        return ((8 - k) > m) ^ inv;
    endfunction

    function automatic logic [31:0] char_of(input logic [7:0] v, input bit seven);
        return seven ? {24'd0, 1'b0, v[6:0]} : {24'd0, v};
    endfunction

    // Drive one frame on rxd
    task automatic send_rx(input logic [7:0] v, input int nb);
        @(negedge clk); rxd = 1'b0;
        repeat (per) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = v[i];
            repeat (per) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (per) @(negedge clk);
    endtask

    // Capture one frame from txd
    task automatic get_tx(input int nb, output logic [7:0] v, output logic stopb);
        int t;
        t = 0;
        v = '0;
        stopb = 1'b0;
        while (txd !== 1'b0 && t < 60 * per) begin
            @(negedge clk); t++;
        end
        if (t >= 60 * per) begin
            nchk++; nfail++;
            $display("FAIL R2 no start bit actual=timeout expected=frame");
        end else begin
            repeat (per / 2) @(negedge clk);
            for (int i = 0; i < nb; i++) begin
                repeat (per) @(negedge clk);
                v[i] = txd;
            end
            repeat (per) @(negedge clk);
            stopb = txd;
            repeat (per / 2 + 3) @(negedge clk);
        end
    endtask

    // Returns 1 if txd stayed high for n cycles
    task automatic quiet(input int n, output bit ok);
        ok = 1;
        repeat (n) begin
            @(negedge clk);
            if (txd !== 1'b1) ok = 0;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  v, got;
        logic [7:0]  ovl [9];
        logic        sb;
        bit          ok;
        int          n, seed;

        seed = $urandom(32'h5eed);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Reset state (R11, R8)
        rd(3'd5, d); chk("R11 reset status", d, 32'h0000_03CE);
        rd(3'd2, d); chk("R8 reset iid", d, 32'h1);
        chk("R8 reset irq", irq, 1'b0);
        chk("R3 reset txd", txd, 1'b1);
        chk("R6 reset rts", rts_out, 1'b1);

        // R1: start bit length for divider 2
        set_baud(2);
        wr(3'd0, 32'h01);
        n = 0;
        while (txd !== 1'b0 && n < 1000) begin @(negedge clk); n++; end
        n = 0;
        while (txd === 1'b0) begin @(negedge clk); n++; end
        chk("R1 bit length div2", n, 24);
        repeat (per * 11) @(negedge clk);

        // R2: random 8-bit frames
        set_baud(1);
        for (int k = 0; k < 10; k++) begin
            v = 8'($urandom);
            wr(3'd0, {24'd0, v});
            get_tx(8, got, sb);
            chk("R2 tx byte", got, v);
            chk("R2 stop bit", sb, 1'b1);
        end
        rd(3'd5, d); chk("R11 tx done", d[9:8], 2'b11);

        // R2 / R4: 7-bit mode
        wr(3'd3, 32'h2);
        wr(3'd0, 32'hFF);
        get_tx(7, got, sb);
        chk("R2 7-bit data", got, 8'h7F);
        chk("R2 7-bit stop", sb, 1'b1);
        send_rx(8'hD5, 7);
        rd(3'd0, d); chk("R4 7-bit rx", d, char_of(8'hD5, 1));
        wr(3'd3, 32'h3);

        // R4: random received bytes
        for (int k = 0; k < 8; k++) begin
            v = 8'($urandom);
            send_rx(v, 8);
            if (k == 0) begin
                rd(3'd5, d); chk("R11 rx data flag", d[0], 1'b1);
            end
            rd(3'd0, d); chk("R4 rx byte", d, char_of(v, 0));
        end
        rd(3'd5, d); chk("R11 rx empty", d[0], 1'b0);

        // R4: short glitch rejected as start bit
        @(negedge clk); rxd = 1'b0;
        repeat (per / 4) @(negedge clk);
        rxd = 1'b1;
        repeat (per * 12) @(negedge clk);
        rd(3'd5, d); chk("R4 glitch rejected", d[23:16], 8'd0);

        // R3: break
        wr(3'd3, 32'h7);
        repeat (5) @(negedge clk);
        chk("R3 break low", txd, 1'b0);
        repeat (50) @(negedge clk);
        chk("R3 break held", txd, 1'b0);
        wr(3'd3, 32'h3);
        repeat (3) @(negedge clk);
        chk("R3 break release", txd, 1'b1);

        // R6: RTS thresholds
        for (int sel = 0; sel < 4; sel++) begin
            wr(3'd4, 32'h07 | (sel << 4));
            wr(3'd2, 32'h1);
            for (int k = 1; k <= 5; k++) begin
                send_rx(8'(k), 8);
                repeat (3) @(negedge clk);
                chk($sformatf("R6 rts sel%0d k%0d", sel, k), rts_out, exp_rts(k, sel, 0));
            end
        end
        rd(3'd5, d); chk("R6 status rts mirror", d[6], rts_out);
        wr(3'd2, 32'h1);
        wr(3'd4, 32'h47);
        repeat (3) @(negedge clk);
        chk("R6 rts inverted", rts_out, exp_rts(0, 0, 1));
        wr(3'd4, 32'h03);
        repeat (3) @(negedge clk);
        chk("R6 rts manual", rts_out, 1'b1);

        // R5: overflow
        wr(3'd2, 32'h1);
        for (int k = 0; k < 9; k++) begin
            ovl[k] = 8'($urandom);
            send_rx(ovl[k], 8);
        end
        rd(3'd5, d);
        chk("R5 overflow set", d[4], 1'b1);
        chk("R5 fill full", d[23:16], 8'd8);
        rd(3'd5, d); chk("R5 overflow cleared", d[4], 1'b0);
        for (int k = 0; k < 8; k++) begin
            rd(3'd0, d); chk("R5 kept bytes", d, {24'd0, ovl[k]});
        end

        // R7: CTS gating
        wr(3'd4, 32'h0B);
        cts_in = 1'b0;
        repeat (5) @(negedge clk);
        wr(3'd0, 32'hA5);
        quiet(20 * per, ok);
        chk("R7 cts blocks", ok, 1'b1);
        rd(3'd5, d); chk("R7 byte held", d[8], 1'b0);
        cts_in = 1'b1;
        get_tx(8, got, sb);
        chk("R7 cts resume", got, 8'hA5);
        wr(3'd4, 32'h8B);
        repeat (5) @(negedge clk);
        wr(3'd0, 32'h3C);
        quiet(20 * per, ok);
        chk("R7 inverted blocks", ok, 1'b1);
        cts_in = 1'b0;
        get_tx(8, got, sb);
        chk("R7 inverted resume", got, 8'h3C);
        wr(3'd4, 32'h03);
        wr(3'd0, 32'h5A);
        get_tx(8, got, sb);
        chk("R7 cts ignored", got, 8'h5A);
        cts_in = 1'b1;

        // R10: enables
        wr(3'd4, 32'h01);
        wr(3'd0, 32'h77);
        quiet(15 * per, ok);
        chk("R10 tx disabled", ok, 1'b1);
        rd(3'd5, d); chk("R10 tx held", d[31:24], 8'd1);
        wr(3'd4, 32'h03);
        get_tx(8, got, sb);
        chk("R10 tx enabled", got, 8'h77);
        wr(3'd4, 32'h02);
        send_rx(8'h12, 8);
        rd(3'd5, d); chk("R10 rx disabled", d[23:16], 8'd0);
        wr(3'd4, 32'h03);

        // R9: flush
        wr(3'd4, 32'h01);
        wr(3'd0, 32'h11); wr(3'd0, 32'h22); wr(3'd0, 32'h33);
        rd(3'd5, d); chk("R9 tx fill", d[31:24], 8'd3);
        wr(3'd2, 32'h2);
        rd(3'd5, d); chk("R9 tx flushed", {d[31:24], 7'd0, d[8]}, 16'h0001);
        wr(3'd4, 32'h03);
        send_rx(8'h44, 8); send_rx(8'h55, 8);
        rd(3'd5, d); chk("R9 rx fill", d[23:16], 8'd2);
        wr(3'd2, 32'h1);
        rd(3'd5, d); chk("R9 rx flushed", d[0], 1'b0);

        // R8: interrupt identification
        wr(3'd1, 32'h1);
        rd(3'd2, d); chk("R8 no rx pending", d, 32'h1);
        chk("R8 irq low", irq, 1'b0);
        send_rx(8'h40, 8);
        rd(3'd2, d); chk("R8 rx pending", d, 32'h4);
        chk("R8 irq high", irq, 1'b1);
        wr(3'd1, 32'h3);
        rd(3'd2, d); chk("R8 rx priority", d, 32'h4);
        rd(3'd0, d);
        rd(3'd2, d); chk("R8 tx pending", d, 32'h2);
        wr(3'd1, 32'h0);
        rd(3'd2, d); chk("R8 none enabled", d, 32'h1);
        chk("R8 irq cleared", irq, 1'b0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule